// File: doc/BRIEF.md
# Multi-Rate Search and Selection Controller

This controller decides which serial data rate a reclocking PLL tries to acquire. It works on a 3-bit rate code that names one of six rates: 143, 177, 270, 360, 540 or 1485/1483.5 Mb/s. In automatic mode it walks a fixed, non-monotonic list of candidate rates. It waits a parameterised dwell period on each one and settles on the first candidate for which the external frequency-lock indication is asserted. In manual mode the rate code is an input and the PLL is pinned to that single rate.

The rate code shares one bidirectional pin. It is modelled as separate `code_in`, `code_out` and `code_oe` signals, and `code_oe` is high only in automatic mode. The block also produces an SD/HD indication, which is high for every standard-definition rate, and a one-hot select for the VCO divider. An ASI-traffic input removes the 177 Mb/s candidate from the automatic search, because idle patterns on ASI links can cause a false lock at that rate. The lock measurement itself is produced outside the block.

Top module: `rate_search_ctrl`

## Requirements
- R1: The applied rate code is one of 000=143, 001=177, 010=270, 011=360, 100=540, 101=1485 Mb/s. In manual mode the input codes 110 and 111 are applied as 000. `div_sel` is one-hot, with bit k set when the applied code equals k.
- R2: In automatic mode while unlocked, each candidate is held for exactly DWELL_CYCLES clock cycles. The candidates are visited in the order 000, 001, 010, 011, 101, 100, and the search then wraps back to 000.
- R3: When `auto_mode` is low, the code on `code_in` is applied one clock later. In that mode `lock_in` and `asi_mode` have no effect and `code_oe` is low. When `auto_mode` is high, `code_oe` is high.
- R4: `sd_hd` is low when the applied code is 101 and high for every other code. While the block is searching, `sd_hd` therefore follows the candidate being tried.
- R5: When `asi_mode` is high in automatic mode, the search skips 001 (000 is followed by 010). If the applied code is 001 when `asi_mode` rises, the block moves to 010 on the next clock, even if `lock_in` is high.
- R6: While `lock_in` is high in automatic mode, the applied code is held. When `lock_in` falls, the current code is held for a full DWELL_CYCLES cycles before the search advances.
- R7: Reset is synchronous and active low. It sets the applied code to 000 and restarts the dwell count. When the block returns to automatic mode from manual mode, the search continues from the code that manual mode applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| auto_mode | input | 1 | 1 = automatic search, 0 = manual rate |
| asi_mode | input | 1 | 1 = leave 177 Mb/s out of the search |
| lock_in | input | 1 | Frequency-lock indication from the PLL |
| code_in | input | 3 | Rate code forced in manual mode |
| code_out | output | 3 | Applied rate code |
| code_oe | output | 1 | Output enable for the rate code pin |
| sd_hd | output | 1 | 1 = SD rate, 0 = HD rate |
| div_sel | output | 6 | One-hot VCO divider select |

## Verification
The bench builds the block with DWELL_CYCLES set to 4, so a complete search cycle takes 24 clocks. This lets the bench sweep several full wraps of the search, with and without the ASI skip, and compare every cycle against a position computed arithmetically from the number of clocks since reset. The bench also drives all eight manual codes, including the two unused ones. Lock hold, lock release, the forced exit from 177 and the return from manual mode all fall within a few dwell windows.

// File: rtl/rate_search_pkg.sv
// Package rate_search_pkg
// Shared rate-code constants and helper functions for the rate search controller.
// Assumes the 3-bit rate code in which values above 5 are unused.
package rate_search_pkg;

    localparam int RATE_W    = 3;
    localparam int NUM_RATES = 6;

    localparam logic [RATE_W-1:0] RC_143  = 3'd0;
    localparam logic [RATE_W-1:0] RC_177  = 3'd1;
    localparam logic [RATE_W-1:0] RC_270  = 3'd2;
    localparam logic [RATE_W-1:0] RC_360  = 3'd3;
    localparam logic [RATE_W-1:0] RC_540  = 3'd4;
    localparam logic [RATE_W-1:0] RC_1485 = 3'd5;

    typedef logic [RATE_W-1:0]    rate_t;
    typedef logic [NUM_RATES-1:0] div_sel_t;

    // Map an unused code to the 143 Mb/s code.
    function automatic rate_t rate_sanitize(input rate_t c);
        return (c > RC_1485) ? RC_143 : c;
    endfunction

    // Next candidate in the search list, optionally skipping 177 Mb/s.
    function automatic rate_t rate_successor(input rate_t c, input logic skip177);
        rate_t n;
        case (c)
            RC_143:  n = skip177 ? RC_270 : RC_177;
            RC_177:  n = RC_270;
            RC_270:  n = RC_360;
            RC_360:  n = RC_1485;
            RC_1485: n = RC_540;
            default: n = RC_143;
        endcase
        return n;
    endfunction

    // True for the high-definition rate.
    function automatic logic rate_is_hd(input rate_t c);
        return (c == RC_1485);
    endfunction

endpackage

// File: rtl/dwell_timer.sv
// Module dwell_timer
// Counts reference-clock cycles spent on one search candidate and pulses
// 'expire' in the last cycle of a window of DWELL_CYCLES cycles.
// Assumes DWELL_CYCLES >= 2. 'restart' or a low 'run' clears the count.
module dwell_timer #(
    parameter int DWELL_CYCLES = 141400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);
    localparam int CW = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DWELL_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Flag the final cycle of the dwell window.
    always_comb begin
        expire = run && !restart && (cnt_q == LAST);
    end

    // Advance the dwell count, wrapping on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            cnt_q <= '0;
        end else if (expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rate_sequencer.sv
// Module rate_sequencer
// Holds the applied rate code and decides when it changes: it follows the
// manual code, holds while locked, and advances on dwell expiry or on a
// forced exit from 177 Mb/s when ASI traffic is selected.
// Assumes the dwell timer is cleared whenever 'dwell_restart' is high.
module rate_sequencer
    import rate_search_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  auto_mode,
    input  logic  asi_mode,
    input  logic  lock_in,
    input  rate_t code_in,
    input  logic  dwell_expire,
    output logic  dwell_run,
    output logic  dwell_restart,
    output rate_t rate_q
);
    logic  forced_leave;
    rate_t rate_d;

    // Decide whether the timer runs and whether the current candidate must be left.
    always_comb begin
        forced_leave  = auto_mode && asi_mode && (rate_q == RC_177);
        dwell_run     = auto_mode && !lock_in && !forced_leave;
        dwell_restart = !auto_mode || lock_in || forced_leave;
    end

    // Choose the next applied rate.
    always_comb begin
        if (!auto_mode) begin
            rate_d = rate_sanitize(code_in);
        end else if (forced_leave || dwell_expire) begin
            rate_d = rate_successor(rate_q, asi_mode);
        end else begin
            rate_d = rate_q;
        end
    end

    // Register the applied rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= RC_143;
        end else begin
            rate_q <= rate_d;
        end
    end

endmodule

// File: rtl/rate_decode.sv
// Module rate_decode
// Turns the applied rate code into the one-hot divider select and the
// SD/HD indication. Purely combinational.
module rate_decode
    import rate_search_pkg::*;
(
    input  rate_t    rate,
    output div_sel_t div_sel,
    output logic     sd_hd
);
    // One decoder bit per supported rate.
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_div
        assign div_sel[g] = (rate == RATE_W'(g));
    end

    // SD/HD indication: high for standard-definition rates.
    always_comb begin
        sd_hd = !rate_is_hd(rate);
    end

endmodule

// File: rtl/rate_search_ctrl.sv
// Module rate_search_ctrl
// Top level of the multi-rate search and selection controller. In automatic
// mode it searches the candidate list and settles on lock. In manual mode it
// applies the forced code. The bidirectional code pin is split into
// in/out/enable signals. Assumes lock_in is synchronous to clk.
module rate_search_ctrl
    import rate_search_pkg::*;
#(
    parameter int DWELL_CYCLES = 141400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_mode,
    input  logic       asi_mode,
    input  logic       lock_in,
    input  logic [2:0] code_in,
    output logic [2:0] code_out,
    output logic       code_oe,
    output logic       sd_hd,
    output logic [5:0] div_sel
);
    logic  dwell_run;
    logic  dwell_restart;
    logic  dwell_expire;
    rate_t rate_q;

    dwell_timer #(
        .DWELL_CYCLES(DWELL_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (dwell_run),
        .restart (dwell_restart),
        .expire  (dwell_expire)
    );

    rate_sequencer u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .auto_mode     (auto_mode),
        .asi_mode      (asi_mode),
        .lock_in       (lock_in),
        .code_in       (code_in),
        .dwell_expire  (dwell_expire),
        .dwell_run     (dwell_run),
        .dwell_restart (dwell_restart),
        .rate_q        (rate_q)
    );

    rate_decode u_dec (
        .rate    (rate_q),
        .div_sel (div_sel),
        .sd_hd   (sd_hd)
    );

    // Drive the code pin only while the code is an output.
    always_comb begin
        code_out = rate_q;
        code_oe  = auto_mode;
    end

endmodule

// File: rtl/rate_search_ctrl_chk.sv
// Module rate_search_ctrl_chk
// Temporal checks on the ports of rate_search_ctrl, attached with bind.
module rate_search_ctrl_chk
    import rate_search_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       auto_mode,
    input logic       asi_mode,
    input logic       lock_in,
    input logic [2:0] code_in,
    input logic [2:0] code_out,
    input logic       code_oe,
    input logic       sd_hd,
    input logic [5:0] div_sel
);
    p_code_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (code_out <= RC_1485) && (div_sel == (6'd1 << code_out)));

    p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && !lock_in) |=>
        ($stable(code_out) || code_out == rate_successor($past(code_out), $past(asi_mode))));

    p_manual_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mode |=> (code_out == rate_sanitize($past(code_in))));

    p_sdhd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sd_hd == (code_out != RC_1485));

    p_no_177_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && asi_mode) |=> (code_out != RC_177));

    p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && lock_in && !(asi_mode && code_out == RC_177)) |=> $stable(code_out));

    p_reset_r7: assert property (@(posedge clk)
        !rst_n |=> (code_out == RC_143));

endmodule

bind rate_search_ctrl rate_search_ctrl_chk u_chk (.*);

// File: tb/rate_search_ctrl_tb.sv
`timescale 1ns/1ps
module rate_search_ctrl_tb;
    localparam int DW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_mode = 1'b1;
    logic       asi_mode = 1'b0;
    logic       lock_in = 1'b0;
    logic [2:0] code_in = 3'd0;
    logic [2:0] code_out;
    logic       code_oe;
    logic       sd_hd;
    logic [5:0] div_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rate_search_ctrl #(.DWELL_CYCLES(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .asi_mode(asi_mode),
        .lock_in(lock_in), .code_in(code_in), .code_out(code_out),
        .code_oe(code_oe), .sd_hd(sd_hd), .div_sel(div_sel)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected code and indicators derived from the requirement text.
    task automatic chk_code(input string req, input int exp);
        chk(req, code_out, exp);
        chk({req, "_R1_div"}, div_sel, 1 << exp);
        chk({req, "_R4_sdhd"}, sd_hd, (exp == 5) ? 0 : 1);
    endtask

    function automatic int order_full(input int i);
        case (i % 6)
            0: return 0; 1: return 1; 2: return 2;
            3: return 3; 4: return 5; default: return 4;
        endcase
    endfunction

    function automatic int order_asi(input int i);
        case (i % 5)
            0: return 0; 1: return 2; 2: return 3;
            3: return 5; default: return 4;
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        chk("R7_reset_code", code_out, 0);
        chk("R7_reset_oe", code_oe, auto_mode);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R7: reset state, automatic mode
        auto_mode = 1'b1;
        do_reset();
        chk_code("R7_after_reset", 0);
        chk("R3_oe_auto", code_oe, 1);

        // R2: full search sweep, three wraps
        for (int n = 1; n <= 3 * 6 * DW; n++) begin
            tick();
            chk_code("R2_search", order_full(n / DW));
        end

        // R5: search with ASI skip
        asi_mode = 1'b1;
        do_reset();
        for (int n = 1; n <= 3 * 5 * DW; n++) begin
            tick();
            chk_code("R5_asi_search", order_asi(n / DW));
        end
        asi_mode = 1'b0;

        // R6: lock holds, then a full dwell before advancing
        do_reset();
        for (int n = 1; n <= 3 * DW; n++) tick();
        chk_code("R2_reach_360", 3);
        lock_in = 1'b1;
        for (int n = 0; n < 40; n++) begin
            tick();
            chk("R6_hold_locked", code_out, 3);
        end
        lock_in = 1'b0;
        for (int n = 1; n < DW; n++) begin
            tick();
            chk("R6_full_dwell_after_unlock", code_out, 3);
        end
        tick();
        chk_code("R6_advance_after_dwell", 5);

        // R5: ASI rising while locked on 177 forces exit
        do_reset();
        for (int n = 1; n <= DW; n++) tick();
        chk_code("R2_reach_177", 1);
        lock_in = 1'b1;
        asi_mode = 1'b1;
        tick();
        chk_code("R5_forced_exit", 2);
        for (int n = 0; n < 10; n++) begin
            tick();
            chk("R5_hold_after_exit", code_out, 2);
        end
        lock_in = 1'b0;
        asi_mode = 1'b0;

        // R1, R3: manual sweep over all eight codes
        auto_mode = 1'b0;
        for (int c = 0; c < 8; c++) begin
            code_in = 3'(c);
            tick();
            chk_code("R1_manual_code", (c < 6) ? c : 0);
            chk("R3_oe_manual", code_oe, 0);
        end

        // R3: manual code ignores lock and ASI
        code_in = 3'd1;
        asi_mode = 1'b1;
        lock_in = 1'b0;
        for (int n = 0; n < 3 * DW; n++) begin
            tick();
            chk("R3_manual_ignores_asi_lock", code_out, 1);
        end
        asi_mode = 1'b0;

        // R7: return to automatic resumes from the manual code
        code_in = 3'd4;
        tick();
        chk_code("R1_manual_540", 4);
        auto_mode = 1'b1;
        #0.5;
        chk("R3_oe_back_auto", code_oe, 1);
        for (int n = 1; n < DW; n++) begin
            tick();
            chk("R7_resume_hold", code_out, 4);
        end
        tick();
        chk_code("R7_resume_wrap", 0);

        finish_run();
    end

endmodule